// File: doc/BRIEF.md
# Reset Cause and Status Registers

This block records why the chip was last reset and what kind of reset came before that. Hardware cause pulses, each one clock cycle long, set sticky bits in a cause register. Software reads that register after boot and clears the bits it has handled by writing ones to them. A status register holds the kind of the current reset (power-on, warm, or frequency-change) next to a shadow copy of the previous kind. Each reset event first moves the current kind into the shadow field and then loads the new kind.

Eight cache-slice fatal-error inputs pass through a fatal-error enable register. An enabled slice error logs its cause bit and asks the reset controller for a warm reset through a small request sequencer. The sequencer is a three-state machine. FSM_IDLE waits for an enabled slice error and then moves to FSM_REQ. FSM_REQ raises the request for one cycle and always moves on to FSM_WAIT. FSM_WAIT ignores further errors until a reset event arrives, and then returns to FSM_IDLE. Every reset event also clears the enable register.

Software reaches the three registers through a flat read/write port. A write takes effect at the clock edge. Read data is combinational, and every bit outside a register's writable mask reads as zero.

Top module: `reset_cause_regs`

## Requirements
- R1: Cause input bits 0, 1, 3, 4, 5, 6 and 7 (software warm, software XIR, software debug, power-on pin, push-button reset pin, push-button XIR pin, I/O-hub fatal) set the same bit position of the cause register (address 0) one edge after their pulse, and the bits stay set. Cause input bit 2 is ignored, and cause register bit 2 always reads 0.
- R2: A pulse on slice_fatal[i] sets cause register bit 8+i only when enable register bit 8+i is 1. With the enable bit at 0 it sets nothing and raises no warm request.
- R3: A write to the cause register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFB clears all logged causes.
- R4: If a cause pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status register (address 1) layout: bit 0 power-on, bit 1 warm, bit 2 frequency, bits 4..6 shadow of bits 0..2. A reset event of kind 0 (power-on) loads 001, kind 1 (warm) loads 010, and kind 2 (frequency-change) loads 110 into bits 2..0. In the same edge, the old bits 2..0 are copied into bits 6..4.
- R6: A reset event of kind 3 and any write to the status register leave the status register unchanged.
- R7: The enable register (address 2) stores bits 8..15 and reads the other bits as 0. Any reset event of kind 0, 1 or 2 clears it to zero, and the clear wins over a write in the same cycle.
- R8: An enabled slice error seen in FSM_IDLE makes warm_req high for exactly the next cycle. Later enabled errors raise no new request until a reset event of kind 0, 1 or 2 has returned the sequencer to FSM_IDLE.
- R9: After reset every register reads zero and warm_req is low. Address 3 reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_cause | input | 8 | One-cycle hardware/software reset-cause pulses, bit positions per R1 |
| slice_fatal | input | 8 | One-cycle fatal-error pulses from cache slices 0..7 |
| rst_evt_valid | input | 1 | A reset event of kind rst_evt_kind occurs this cycle |
| rst_evt_kind | input | 2 | 0 power-on, 1 warm, 2 frequency-change, 3 none |
| reg_addr | input | 2 | Register address: 0 cause, 1 status, 2 enable, 3 unmapped |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Masked read data for reg_addr |
| warm_req | output | 1 | One-cycle warm-reset request caused by an enabled slice error |

## Verification
The bench aims at the same-cycle collisions. A clear that beat a cause pulse would drop a cause bit that has just been logged. An enable write that beat a reset event would leave slice errors armed after the reset. It checks the shadow field across a chain of power-on, warm, frequency and warm events. A design that loaded the new kind before copying would show the new kind in the shadow field. It also checks the reserved cause bit 2, writes of zeros to the cause register, the ignored status writes and event kind 3. Any of these mistakes shows up as a wrong read value. It walks the request sequencer through a disabled slice, a single enabled slice, repeated errors while waiting, and a reset event that disarms the enables. A sequencer that re-armed early, or held the request longer than one cycle, would show an extra or stretched warm_req.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic [1:0] {
        KIND_POR  = 2'd0,
        KIND_WARM = 2'd1,
        KIND_FREQ = 2'd2,
        KIND_NONE = 2'd3
    } rst_kind_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_REQ  = 2'd1,
        FSM_WAIT = 2'd2
    } fatal_fsm_e;

    localparam logic [1:0] ADDR_CAUSE  = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_ENABLE = 2'd2;

    localparam int CAUSE_W      = 8;
    localparam int SLICE_LSB    = CAUSE_W;
    localparam int STAT_W       = 8;
    localparam int SHADOW_LSB   = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_LIVE = 8'hFB;
    localparam logic [STAT_W-1:0]  STAT_LIVE  = 8'h77;

endpackage

// File: rtl/rcs_cause_reg.sv
module rcs_cause_reg
    import rcs_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int REG_W = SLICE_LSB + NUM_SLICES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CAUSE_W-1:0]    hw_cause,
    input  logic [NUM_SLICES-1:0] slice_hit,
    input  logic                  clr_en,
    input  logic [REG_W-1:0]      clr_data,
    output logic [REG_W-1:0]      cause_q
);

    localparam logic [REG_W-1:0] LIVE = {{NUM_SLICES{1'b1}}, CAUSE_LIVE};

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        set_vec = {slice_hit, hw_cause} & LIVE;
        clr_vec = clr_en ? (clr_data & LIVE) : '0;
    end

    // set is ORed after the clear, so a same-cycle pulse survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  rst_kind_e         evt_kind,
    output logic [STAT_W-1:0] stat_q
);

    logic [2:0] kind_code;
    logic       load;

    always_comb begin
        kind_code = 3'b000;
        load      = 1'b0;
        unique case (evt_kind)
            KIND_POR:  begin kind_code = 3'b001; load = evt_valid; end
            KIND_WARM: begin kind_code = 3'b010; load = evt_valid; end
            KIND_FREQ: begin kind_code = 3'b110; load = evt_valid; end
            KIND_NONE: begin kind_code = 3'b000; load = 1'b0;      end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (load) begin
            stat_q[SHADOW_LSB+2:SHADOW_LSB] <= stat_q[2:0];
            stat_q[2:0]                     <= kind_code;
        end
    end

endmodule

// File: rtl/rcs_fatal_ctl.sv
module rcs_fatal_ctl
    import rcs_pkg::*;
#(
    parameter int NUM_SLICES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NUM_SLICES-1:0] wr_data,
    input  logic [NUM_SLICES-1:0] slice_fatal,
    input  logic                  rst_evt,
    output logic [NUM_SLICES-1:0] enable_q,
    output logic [NUM_SLICES-1:0] slice_hit,
    output logic                  warm_req
);

    fatal_fsm_e state_q, state_d;
    logic       any_hit;

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_gate
            assign slice_hit[s] = slice_fatal[s] & enable_q[s];
        end
    endgenerate

    assign any_hit = |slice_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       enable_q <= '0;
        else if (rst_evt) enable_q <= '0;
        else if (wr_en)   enable_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: if (any_hit) state_d = FSM_REQ;
            FSM_REQ:               state_d = FSM_WAIT;
            FSM_WAIT: if (rst_evt) state_d = FSM_IDLE;
            default:               state_d = FSM_IDLE;
        endcase
    end

    always_comb begin
        warm_req = (state_q == FSM_REQ);
    end

endmodule

// File: rtl/reset_cause_regs.sv
module reset_cause_regs
    import rcs_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int REG_W = SLICE_LSB + NUM_SLICES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CAUSE_W-1:0]    hw_cause,
    input  logic [NUM_SLICES-1:0] slice_fatal,
    input  logic                  rst_evt_valid,
    input  logic [1:0]            rst_evt_kind,
    input  logic [1:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  warm_req
);

    rst_kind_e             kind;
    logic                  evt_live;
    logic                  wr_cause;
    logic                  wr_enable;
    logic [REG_W-1:0]      cause_q;
    logic [STAT_W-1:0]     stat_q;
    logic [NUM_SLICES-1:0] enable_q;
    logic [NUM_SLICES-1:0] slice_hit;

    always_comb begin
        kind      = rst_kind_e'(rst_evt_kind);
        evt_live  = rst_evt_valid && (kind != KIND_NONE);
        wr_cause  = reg_we && (reg_addr == ADDR_CAUSE);
        wr_enable = reg_we && (reg_addr == ADDR_ENABLE);
    end

    rcs_cause_reg #(.NUM_SLICES(NUM_SLICES)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_cause  (hw_cause),
        .slice_hit (slice_hit),
        .clr_en    (wr_cause),
        .clr_data  (reg_wdata),
        .cause_q   (cause_q)
    );

    rcs_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (rst_evt_valid),
        .evt_kind  (kind),
        .stat_q    (stat_q)
    );

    rcs_fatal_ctl #(.NUM_SLICES(NUM_SLICES)) u_fatal (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_enable),
        .wr_data     (reg_wdata[REG_W-1:SLICE_LSB]),
        .slice_fatal (slice_fatal),
        .rst_evt     (evt_live),
        .enable_q    (enable_q),
        .slice_hit   (slice_hit),
        .warm_req    (warm_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CAUSE:  reg_rdata = cause_q;
            ADDR_STATUS: reg_rdata[STAT_W-1:0] = stat_q & STAT_LIVE;
            ADDR_ENABLE: reg_rdata[REG_W-1:SLICE_LSB] = enable_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/reset_cause_regs_chk.sv
module reset_cause_regs_chk
    import rcs_pkg::*;
#(
    parameter int NUM_SLICES = 8,
    localparam int REG_W = SLICE_LSB + NUM_SLICES
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CAUSE_W-1:0]    hw_cause,
    input logic [NUM_SLICES-1:0] slice_fatal,
    input logic                  rst_evt_valid,
    input logic [1:0]            rst_evt_kind,
    input logic [1:0]            reg_addr,
    input logic [REG_W-1:0]      reg_rdata,
    input logic                  warm_req,
    input logic [REG_W-1:0]      cause_q,
    input logic [STAT_W-1:0]     stat_q,
    input logic [NUM_SLICES-1:0] enable_q
);

    logic evt_live;
    assign evt_live = rst_evt_valid && (rst_evt_kind != 2'd3);

    AST_CAUSE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_cause[0] |=> cause_q[0]); // R4

    AST_CAUSE_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_q[2]); // R1

    AST_SLICE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_fatal[0] && !enable_q[0] && !cause_q[SLICE_LSB]) |=> !cause_q[SLICE_LSB]); // R2

    AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_live |=> (stat_q[SHADOW_LSB+2:SHADOW_LSB] == $past(stat_q[2:0]))); // R5

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_q[1:0]) && (!stat_q[2] || stat_q[1])); // R5

    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_live |=> (enable_q == '0)); // R7

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req |=> !warm_req); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0)); // R9

endmodule

bind reset_cause_regs reset_cause_regs_chk #(.NUM_SLICES(NUM_SLICES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_cause      (hw_cause),
    .slice_fatal   (slice_fatal),
    .rst_evt_valid (rst_evt_valid),
    .rst_evt_kind  (rst_evt_kind),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .warm_req      (warm_req),
    .cause_q       (cause_q),
    .stat_q        (stat_q),
    .enable_q      (enable_q)
);

// File: tb/reset_cause_regs_tb_top.sv
`timescale 1ns/1ps
module reset_cause_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hw_cause = '0;
    logic [7:0]  slice_fatal = '0;
    logic        rst_evt_valid = 1'b0;
    logic [1:0]  rst_evt_kind = 2'd3;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        warm_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    reset_cause_regs dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_cause      (hw_cause),
        .slice_fatal   (slice_fatal),
        .rst_evt_valid (rst_evt_valid),
        .rst_evt_kind  (rst_evt_kind),
        .reg_addr      (reg_addr),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .warm_req      (warm_req)
    );

    // fields: we addr wdata cause slice ev kind chk_addr expected req
    localparam int NV = 16;
    localparam logic [59:0] VEC [NV] = '{
        {1'b0, 2'd0, 16'h0000, 8'h01, 8'h00, 1'b0, 2'd3, 2'd0, 16'h0001, 4'd1}, // R1
        {1'b0, 2'd0, 16'h0000, 8'hFC, 8'h00, 1'b0, 2'd3, 2'd0, 16'h00F9, 4'd1}, // R1
        {1'b1, 2'd0, 16'h0009, 8'h00, 8'h00, 1'b0, 2'd3, 2'd0, 16'h00F0, 4'd3}, // R3
        {1'b1, 2'd0, 16'hFFFB, 8'h00, 8'h00, 1'b0, 2'd3, 2'd0, 16'h0000, 4'd3}, // R3
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'hFF, 1'b0, 2'd3, 2'd0, 16'h0000, 4'd2}, // R2
        {1'b1, 2'd2, 16'hFFFF, 8'h00, 8'h00, 1'b0, 2'd3, 2'd2, 16'hFF00, 4'd7}, // R7
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h05, 1'b0, 2'd3, 2'd0, 16'h0500, 4'd2}, // R2
        {1'b1, 2'd0, 16'h0101, 8'h01, 8'h01, 1'b0, 2'd3, 2'd0, 16'h0501, 4'd4}, // R4
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 2'd0, 2'd1, 16'h0001, 4'd5}, // R5
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 2'd1, 2'd1, 16'h0012, 4'd5}, // R5
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 2'd2, 2'd1, 16'h0026, 4'd5}, // R5
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 2'd3, 2'd1, 16'h0026, 4'd6}, // R6
        {1'b1, 2'd1, 16'hFFFF, 8'h00, 8'h00, 1'b0, 2'd3, 2'd1, 16'h0026, 4'd6}, // R6
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 2'd3, 2'd2, 16'h0000, 4'd7}, // R7
        {1'b1, 2'd3, 16'hFFFF, 8'h00, 8'h00, 1'b0, 2'd3, 2'd3, 16'h0000, 4'd9}, // R9
        {1'b0, 2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 2'd1, 2'd1, 16'h0062, 4'd5}  // R5
    };

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(string tag, logic [1:0] a, logic [15:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    // drive at a falling edge, let one rising edge pass, then release pulses
    task automatic step();
        @(negedge clk);
        reg_we = 1'b0; hw_cause = '0; slice_fatal = '0;
        rst_evt_valid = 1'b0; rst_evt_kind = 2'd3;
    endtask

    task automatic write_reg(logic [1:0] a, logic [15:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset values
        read_chk("R9 cause after reset", 2'd0, 16'h0000);
        read_chk("R9 status after reset", 2'd1, 16'h0000);
        read_chk("R9 enable after reset", 2'd2, 16'h0000);
        check("R9 warm_req after reset", {15'd0, warm_req}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            v = VEC[i];
            reg_we = v[59]; reg_addr = v[58:57]; reg_wdata = v[56:41];
            hw_cause = v[40:33]; slice_fatal = v[32:25];
            rst_evt_valid = v[24]; rst_evt_kind = v[23:22];
            step();
            read_chk($sformatf("R%0d vector %0d", v[3:0], i), v[21:20], v[19:4]);
        end

        // R2 / R8: request sequencer
        write_reg(2'd2, 16'h0100);
        slice_fatal = 8'h02; step();
        check("R2 disabled slice no request", {15'd0, warm_req}, 16'h0000);
        slice_fatal = 8'h01; step();
        check("R8 request raised", {15'd0, warm_req}, 16'h0001);
        step();
        check("R8 request one cycle", {15'd0, warm_req}, 16'h0000);
        slice_fatal = 8'h01; step();
        check("R8 no request while waiting", {15'd0, warm_req}, 16'h0000);
        step();
        check("R8 still no request", {15'd0, warm_req}, 16'h0000);
        rst_evt_valid = 1'b1; rst_evt_kind = 2'd1; step();
        read_chk("R7 enable cleared by warm event", 2'd2, 16'h0000);
        slice_fatal = 8'h01; step();
        check("R2 cleared enable blocks request", {15'd0, warm_req}, 16'h0000);
        write_reg(2'd2, 16'h0100);
        slice_fatal = 8'h01; step();
        check("R8 re-armed request", {15'd0, warm_req}, 16'h0001);

        // R7: event beats write in same cycle
        reg_addr = 2'd2; reg_we = 1'b1; reg_wdata = 16'hFF00;
        rst_evt_valid = 1'b1; rst_evt_kind = 2'd0; step();
        read_chk("R7 event beats write", 2'd2, 16'h0000);

        // R3: writing zeros changes nothing
        read_chk("R3 cause before zero write", 2'd0, 16'h0501);
        write_reg(2'd0, 16'h0000);
        read_chk("R3 zero write keeps causes", 2'd0, 16'h0501);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule